// File: doc/BRIEF.md
# Radix Address-Space Qualifier

This block sits in front of a radix page-table translation unit. For each access request it takes the 64-bit effective address, the access kind and the current mode bits, and decides one of three outcomes. The access may bypass translation as a real-mode access, with a physical address formed directly. It may go to the table walker carrying the partition and process identifiers that qualify the address. Or it may be rejected with a segment interrupt.

The two most significant address bits select one of four quadrants. In hypervisor state every quadrant maps to its own identifier pair. In guest state only the application quadrant and the kernel quadrant are legal. The result is registered and appears one cycle after the request, marked by a single-cycle valid pulse.

Top module: `radix_addr_qualifier`

## Requirements
- R1: Access kind is encoded 0 load, 1 store, 2 fetch, 3 treated as load. Relocation is active for a fetch when `ir_en_i` is set, and for any other kind when `dr_en_i` is set.
- R2: Real mode is selected when relocation is inactive and the effective hypervisor state holds. The real address is then the effective address with bits 63:60 forced to zero. `real_mode_o` is 1, and the identifiers, `reloc_o` and `seg_fault_o` are 0.
- R3: In real mode, `rmor_i` is ORed into the real address when effective-address bit 63 is 0, and is not applied when bit 63 is 1.
- R4: With relocation in hypervisor state, the quadrant is ea[63:62]. Quadrant 0 gives LPID 0 with the PID register. Quadrant 1 gives both registers. Quadrant 2 gives the LPID register with PID 0. Quadrant 3 gives LPID 0 and PID 0. `reloc_o` is 1 in all four cases.
- R5: With relocation in guest state, quadrant 0 gives the LPID and PID registers, and quadrant 3 gives the LPID register with PID 0. `reloc_o` is 1.
- R6: With relocation in guest state, quadrants 1 and 2 raise `seg_fault_o`. `seg_fault_inst_o` is 1 for a fetch and 0 otherwise. `fault_addr_o` carries the effective address for a data access and 0 for a fetch. `reloc_o`, `real_mode_o` and both identifiers are 0.
- R7: In guest state with relocation inactive, the output has `reloc_o` 0, LPID equal to the LPID register and PID 0. There is no fault for any quadrant, and `real_mode_o` is 0.
- R8: When `hv_present_i` is 0, the effective hypervisor state holds regardless of `hv_mode_i`.
- R9: A request sampled at a clock edge produces its result and a `rsp_valid_o` pulse after that edge, in the next cycle. `rsp_valid_o` is 0 in every cycle that follows no request.
- R10: After reset all outputs are 0. At most one of `real_mode_o`, `reloc_o` and `seg_fault_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| ea_i | input | 64 | Effective address |
| acc_type_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| hv_mode_i | input | 1 | Hypervisor state bit |
| ir_en_i | input | 1 | Instruction relocation enable |
| dr_en_i | input | 1 | Data relocation enable |
| hv_present_i | input | 1 | Hypervisor state is implemented |
| lpid_reg_i | input | 32 | Partition identifier register |
| pid_reg_i | input | 32 | Process identifier register |
| rmor_i | input | 64 | Real-mode offset register |
| rsp_valid_o | output | 1 | One-cycle result strobe |
| real_mode_o | output | 1 | Result is a real-mode address |
| real_addr_o | output | 64 | Real-mode physical address |
| reloc_o | output | 1 | Translation required with the given identifiers |
| lpid_o | output | 32 | Qualifying partition identifier |
| pid_o | output | 32 | Qualifying process identifier |
| seg_fault_o | output | 1 | Segment interrupt raised |
| seg_fault_inst_o | output | 1 | Segment interrupt is of the instruction kind |
| fault_addr_o | output | 64 | Faulting address for a data segment interrupt |

## Verification
Directed cases walk all four quadrants under hypervisor state, guest state and absent-hypervisor state, with each access kind. This separates a quadrant decode error from a mode-selection error. Real-mode cases set and clear address bit 63 with a nonzero offset, and place nonzero values in bits 63:60, so that the masking and the offset merge fail independently. Random requests with sparse gaps vary the relocation enables against the access kind, which exposes a swapped instruction/data enable. The gaps also confirm that the valid pulse lasts exactly one cycle.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    QD_USER = 2'd0,
    QD_LOW  = 2'd1,
    QD_HIGH = 2'd2,
    QD_KERN = 2'd3
  } quad_e;

  typedef struct packed {
    logic real_mode;
    logic reloc;
    logic seg_fault;
    logic seg_inst;
  } kind_t;
endpackage

// File: rtl/rq_mode_decide.sv
module rq_mode_decide
  import rq_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int DROP_BITS = 4
) (
  input  logic [EA_W-1:0] ea_i,
  input  logic [1:0]      acc_type_i,
  input  logic            hv_mode_i,
  input  logic            hv_present_i,
  input  logic            ir_en_i,
  input  logic            dr_en_i,
  input  logic [EA_W-1:0] rmor_i,
  output logic            reloc_o,
  output logic            hv_eff_o,
  output logic            real_mode_o,
  output logic            fetch_o,
  output logic [EA_W-1:0] real_addr_o
);
  localparam int KEEP_W = EA_W - DROP_BITS;

  logic [EA_W-1:0] masked;

  assign fetch_o     = (acc_e'(acc_type_i) == ACC_FETCH);
  assign reloc_o     = fetch_o ? ir_en_i : dr_en_i;
  // no hypervisor implemented: behaves as bare metal
  assign hv_eff_o    = hv_mode_i | ~hv_present_i;
  assign real_mode_o = ~reloc_o & hv_eff_o;

  assign masked      = {{DROP_BITS{1'b0}}, ea_i[KEEP_W-1:0]};
  assign real_addr_o = ea_i[EA_W-1] ? masked : (masked | rmor_i);
endmodule

// File: rtl/rq_quadrant_map.sv
module rq_quadrant_map
  import rq_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic [1:0]      quad_i,
  input  logic            hv_eff_i,
  input  logic            reloc_i,
  input  logic [ID_W-1:0] lpid_reg_i,
  input  logic [ID_W-1:0] pid_reg_i,
  output logic [ID_W-1:0] lpid_o,
  output logic [ID_W-1:0] pid_o,
  output logic            illegal_o
);
  always_comb begin
    lpid_o    = '0;
    pid_o     = '0;
    illegal_o = 1'b0;
    if (!reloc_i) begin
      // real mode (hv) keeps zeros; guest real access is partition scoped
      if (!hv_eff_i) lpid_o = lpid_reg_i;
    end else if (hv_eff_i) begin
      unique case (quad_e'(quad_i))
        QD_USER: pid_o = pid_reg_i;
        QD_LOW: begin
          lpid_o = lpid_reg_i;
          pid_o  = pid_reg_i;
        end
        QD_HIGH: lpid_o = lpid_reg_i;
        QD_KERN: ;
        default: ;
      endcase
    end else begin
      unique case (quad_e'(quad_i))
        QD_USER: begin
          lpid_o = lpid_reg_i;
          pid_o  = pid_reg_i;
        end
        QD_KERN: lpid_o = lpid_reg_i;
        default: illegal_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rq_result_reg.sv
module rq_result_reg
  import rq_pkg::*;
#(
  parameter int EA_W = 64,
  parameter int ID_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  kind_t           kind_i,
  input  logic [EA_W-1:0] real_addr_i,
  input  logic [ID_W-1:0] lpid_i,
  input  logic [ID_W-1:0] pid_i,
  input  logic [EA_W-1:0] fault_addr_i,
  output logic            valid_o,
  output kind_t           kind_o,
  output logic [EA_W-1:0] real_addr_o,
  output logic [ID_W-1:0] lpid_o,
  output logic [ID_W-1:0] pid_o,
  output logic [EA_W-1:0] fault_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      kind_o       <= '0;
      real_addr_o  <= '0;
      lpid_o       <= '0;
      pid_o        <= '0;
      fault_addr_o <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        kind_o       <= kind_i;
        real_addr_o  <= real_addr_i;
        lpid_o       <= lpid_i;
        pid_o        <= pid_i;
        fault_addr_o <= fault_addr_i;
      end
    end
  end
endmodule

// File: rtl/radix_addr_qualifier.sv
module radix_addr_qualifier
  import rq_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int ID_W      = 32,
  parameter int DROP_BITS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [EA_W-1:0] ea_i,
  input  logic [1:0]      acc_type_i,
  input  logic            hv_mode_i,
  input  logic            ir_en_i,
  input  logic            dr_en_i,
  input  logic            hv_present_i,
  input  logic [ID_W-1:0] lpid_reg_i,
  input  logic [ID_W-1:0] pid_reg_i,
  input  logic [EA_W-1:0] rmor_i,
  output logic            rsp_valid_o,
  output logic            real_mode_o,
  output logic [EA_W-1:0] real_addr_o,
  output logic            reloc_o,
  output logic [ID_W-1:0] lpid_o,
  output logic [ID_W-1:0] pid_o,
  output logic            seg_fault_o,
  output logic            seg_fault_inst_o,
  output logic [EA_W-1:0] fault_addr_o
);
  localparam int QLO = EA_W - 2;

  logic            reloc, hv_eff, real_mode, fetch, illegal;
  logic [EA_W-1:0] raddr, raddr_q, faddr;
  logic [ID_W-1:0] lpid_c, pid_c;
  kind_t           kind_d, kind_q;

  rq_mode_decide #(.EA_W(EA_W), .DROP_BITS(DROP_BITS)) u_mode (
    .ea_i        (ea_i),
    .acc_type_i  (acc_type_i),
    .hv_mode_i   (hv_mode_i),
    .hv_present_i(hv_present_i),
    .ir_en_i     (ir_en_i),
    .dr_en_i     (dr_en_i),
    .rmor_i      (rmor_i),
    .reloc_o     (reloc),
    .hv_eff_o    (hv_eff),
    .real_mode_o (real_mode),
    .fetch_o     (fetch),
    .real_addr_o (raddr)
  );

  rq_quadrant_map #(.ID_W(ID_W)) u_quad (
    .quad_i    (ea_i[EA_W-1:QLO]),
    .hv_eff_i  (hv_eff),
    .reloc_i   (reloc),
    .lpid_reg_i(lpid_reg_i),
    .pid_reg_i (pid_reg_i),
    .lpid_o    (lpid_c),
    .pid_o     (pid_c),
    .illegal_o (illegal)
  );

  always_comb begin
    kind_d.real_mode = real_mode;
    kind_d.seg_fault = illegal;
    kind_d.seg_inst  = illegal & fetch;
    kind_d.reloc     = reloc & ~illegal;
    faddr            = (illegal && !fetch) ? ea_i : '0;
  end

  rq_result_reg #(.EA_W(EA_W), .ID_W(ID_W)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (req_valid_i),
    .kind_i      (kind_d),
    .real_addr_i (real_mode ? raddr : '0),
    .lpid_i      (lpid_c),
    .pid_i       (pid_c),
    .fault_addr_i(faddr),
    .valid_o     (rsp_valid_o),
    .kind_o      (kind_q),
    .real_addr_o (raddr_q),
    .lpid_o      (lpid_o),
    .pid_o       (pid_o),
    .fault_addr_o(fault_addr_o)
  );

  assign real_mode_o      = kind_q.real_mode;
  assign reloc_o          = kind_q.reloc;
  assign seg_fault_o      = kind_q.seg_fault;
  assign seg_fault_inst_o = kind_q.seg_inst;
  assign real_addr_o      = raddr_q;
endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
  parameter int EA_W = 64,
  parameter int ID_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [EA_W-1:0] ea_i,
  input logic [1:0]      acc_type_i,
  input logic            hv_mode_i,
  input logic            ir_en_i,
  input logic            dr_en_i,
  input logic            hv_present_i,
  input logic            rsp_valid_o,
  input logic            real_mode_o,
  input logic [EA_W-1:0] real_addr_o,
  input logic            reloc_o,
  input logic [ID_W-1:0] lpid_o,
  input logic [ID_W-1:0] pid_o,
  input logic            seg_fault_o,
  input logic            seg_fault_inst_o,
  input logic [EA_W-1:0] fault_addr_o
);
  logic chk_reloc, chk_hv, chk_bad_q;
  assign chk_reloc = (acc_type_i == 2'd2) ? ir_en_i : dr_en_i;
  assign chk_hv    = hv_mode_i || !hv_present_i;
  assign chk_bad_q = ea_i[EA_W-1] != ea_i[EA_W-2];

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_kind_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({real_mode_o, reloc_o, seg_fault_o}));
  p_real_high_ea_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !chk_reloc && chk_hv && ea_i[EA_W-1]
    |=> real_mode_o && real_addr_o == {4'b0, $past(ea_i[EA_W-5:0])});
  p_guest_bad_quad_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && chk_reloc && !chk_hv && chk_bad_q
    |=> seg_fault_o && !reloc_o && lpid_o == '0 && pid_o == '0);
  p_inst_fault_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_fault_inst_o |-> seg_fault_o && fault_addr_o == '0);
  p_hv_kernel_quad_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && chk_reloc && chk_hv && ea_i[EA_W-1:EA_W-2] == 2'b11
    |=> reloc_o && lpid_o == '0 && pid_o == '0);
  p_guest_real_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !chk_reloc && !chk_hv
    |=> !reloc_o && !seg_fault_o && !real_mode_o && pid_o == '0);
endmodule

bind radix_addr_qualifier rq_checker #(.EA_W(EA_W), .ID_W(ID_W)) u_rq_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .ea_i            (ea_i),
  .acc_type_i      (acc_type_i),
  .hv_mode_i       (hv_mode_i),
  .ir_en_i         (ir_en_i),
  .dr_en_i         (dr_en_i),
  .hv_present_i    (hv_present_i),
  .rsp_valid_o     (rsp_valid_o),
  .real_mode_o     (real_mode_o),
  .real_addr_o     (real_addr_o),
  .reloc_o         (reloc_o),
  .lpid_o          (lpid_o),
  .pid_o           (pid_o),
  .seg_fault_o     (seg_fault_o),
  .seg_fault_inst_o(seg_fault_inst_o),
  .fault_addr_o    (fault_addr_o)
);

// File: tb/tb_radix_addr_qualifier.sv
module tb_radix_addr_qualifier;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [63:0] ea_i = '0;
  logic [1:0]  acc_type_i = '0;
  logic        hv_mode_i = 1'b0, ir_en_i = 1'b0, dr_en_i = 1'b0, hv_present_i = 1'b1;
  logic [31:0] lpid_reg_i = 32'h0000_0a5c, pid_reg_i = 32'h0000_1234;
  logic [63:0] rmor_i = 64'h0000_0000_4000_0000;
  logic        rsp_valid_o, real_mode_o, reloc_o, seg_fault_o, seg_fault_inst_o;
  logic [63:0] real_addr_o, fault_addr_o;
  logic [31:0] lpid_o, pid_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  radix_addr_qualifier dut (.*);

  typedef struct packed {
    logic        real_mode;
    logic [63:0] raddr;
    logic        reloc;
    logic [31:0] lpid;
    logic [31:0] pid;
    logic        fault;
    logic        finst;
    logic [63:0] faddr;
  } exp_t;

  function automatic exp_t model(logic [63:0] ea, logic [1:0] at, logic hv, logic ir,
                                 logic dr, logic hp, logic [31:0] lp, logic [31:0] pd,
                                 logic [63:0] rm);
    exp_t e = '0;
    logic rel = (at == 2'd2) ? ir : dr;
    logic hve = hv | ~hp;
    logic [1:0] q = ea[63:62];
    if (!rel && hve) begin
      e.real_mode = 1'b1;
      e.raddr = ea & 64'h0fff_ffff_ffff_ffff;
      if (!ea[63]) e.raddr = e.raddr | rm;
    end else if (!rel) begin
      e.lpid = lp;
    end else if (hve) begin
      e.reloc = 1'b1;
      e.lpid = (q == 2'd1 || q == 2'd2) ? lp : '0;
      e.pid  = (q == 2'd0 || q == 2'd1) ? pd : '0;
    end else if (q == 2'd0 || q == 2'd3) begin
      e.reloc = 1'b1;
      e.lpid = lp;
      e.pid  = (q == 2'd0) ? pd : '0;
    end else begin
      e.fault = 1'b1;
      e.finst = (at == 2'd2);
      e.faddr = (at == 2'd2) ? '0 : ea;
    end
    return e;
  endfunction

  function automatic string tag_of(exp_t e, logic hp);
    if (!hp) return "R8";
    if (e.fault) return "R6";
    if (e.real_mode) return "R2/R3";
    if (!e.reloc) return "R7";
    if (e.lpid == lpid_reg_i && !(e.pid == '0 && e.lpid == '0)) return "R4/R5";
    return "R4";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_req(logic [63:0] ea, logic [1:0] at, logic hv, logic ir, logic dr,
                         logic hp, string tag_in);
    exp_t e;
    string tg;
    @(negedge clk_i);
    ea_i = ea; acc_type_i = at; hv_mode_i = hv; ir_en_i = ir; dr_en_i = dr;
    hv_present_i = hp; req_valid_i = 1'b1;
    e = model(ea, at, hv, ir, dr, hp, lpid_reg_i, pid_reg_i, rmor_i);
    tg = (tag_in.len() != 0) ? tag_in : tag_of(e, hp);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(rsp_valid_o == 1'b1, "R9", "valid", 64'(rsp_valid_o), 64'd1);
    check(real_mode_o == e.real_mode && reloc_o == e.reloc && seg_fault_o == e.fault
          && seg_fault_inst_o == e.finst, tg, "kind",
          {60'd0, real_mode_o, reloc_o, seg_fault_o, seg_fault_inst_o},
          {60'd0, e.real_mode, e.reloc, e.fault, e.finst});
    check(real_addr_o == e.raddr, tg, "real_addr", real_addr_o, e.raddr);
    check(lpid_o == e.lpid && pid_o == e.pid, tg, "ids", {lpid_o, pid_o}, {e.lpid, e.pid});
    check(fault_addr_o == e.faddr, tg, "fault_addr", fault_addr_o, e.faddr);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog R9 actual=%0d expected=<100000", cycles);
        done = 1'b1;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #35;
    check(rsp_valid_o == 0 && real_mode_o == 0 && reloc_o == 0 && seg_fault_o == 0
          && lpid_o == 0 && pid_o == 0 && real_addr_o == 0, "R10", "reset",
          {59'd0, rsp_valid_o, real_mode_o, reloc_o, seg_fault_o, 1'b0}, 64'd0);
    rst_ni = 1'b1;

    // R2 R3: real mode, both values of bit 63, junk in 62:60
    run_req(64'h7abc_0000_0000_1000, 2'd0, 1, 1, 0, 1, "R3");
    run_req(64'hf123_4567_89ab_cdef, 2'd1, 1, 1, 0, 1, "R3");
    run_req(64'h5000_0000_0000_0040, 2'd2, 1, 0, 1, 1, "R2");
    // R1: fetch follows ir only, load follows dr only
    run_req(64'h4000_0000_0000_0000, 2'd2, 1, 1, 0, 1, "R1");
    run_req(64'h4000_0000_0000_0000, 2'd0, 1, 0, 1, 1, "R1");
    run_req(64'h4000_0000_0000_0000, 2'd3, 1, 1, 0, 1, "R1");
    // R4: hypervisor quadrants
    for (int q = 0; q < 4; q++)
      run_req({2'(q), 62'h1_2345_6789}, 2'd0, 1, 1, 1, 1, "R4");
    // R5 R6: guest quadrants with each access kind
    for (int q = 0; q < 4; q++)
      for (int a = 0; a < 3; a++)
        run_req({2'(q), 62'h3_0000_0abc}, 2'(a), 0, 1, 1, 1,
                (q == 1 || q == 2) ? "R6" : "R5");
    // R7: guest, relocation off, illegal quadrant still no fault
    run_req(64'h4000_0000_0000_0100, 2'd1, 0, 1, 0, 1, "R7");
    run_req(64'h8000_0000_0000_0100, 2'd2, 0, 0, 1, 1, "R7");
    // R8: no hypervisor implemented, hv bit clear
    run_req(64'h4000_0000_0000_0200, 2'd0, 0, 1, 1, 0, "R8");
    run_req(64'h0000_0000_0000_0200, 2'd0, 0, 0, 0, 0, "R8");
    // R9: idle cycle must not pulse valid
    @(negedge clk_i);
    check(rsp_valid_o == 1'b0, "R9", "idle valid", 64'(rsp_valid_o), 64'd0);

    for (int i = 0; i < 400; i++) begin
      lpid_reg_i = $urandom;
      pid_reg_i  = $urandom;
      rmor_i     = {$urandom, $urandom};
      run_req({$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), ($urandom % 4) != 0, "");
      if (($urandom % 5) == 0) begin
        @(negedge clk_i);
        check(rsp_valid_o == 1'b0, "R9", "gap valid", 64'(rsp_valid_o), 64'd0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (done);
    #1;
    if (cycles > 100000) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule